// File: doc/BRIEF.md
# Forced-Idle Residency Counter

This block keeps, for each hardware thread of a core, a running total of the reference-timer ticks that the thread has spent held in the forced-idle state. It keeps one more total for the core as a whole, which counts a tick whenever at least one thread is forced idle. Each total is 64 bits wide, cannot be written, and clears to zero on reset. A tick is counted only on a cycle where the reference tick enable is high, so the totals move at the timestamp rate and not at the core clock rate.

Each idle episode has its own private interval counter. The interval counter starts again on idle entry and counts ticks while the source stays idle. On the first busy cycle after an episode, its value is added to the visible total in one step. The visible total therefore stays flat during the stall and jumps when the stall ends. A capability strap enables the whole feature. While the strap is low, episodes are discarded and every read returns zero.

Reads use a valid/ready request channel that carries a source index: threads 0 to NUM_THREADS-1, and NUM_THREADS for the core aggregate. Results come back on a registered valid/ready response channel. A request is accepted when the response slot is empty or is being drained in the same cycle. While the response is valid and not taken, it holds its value.

Top module: `idle_residency`

## Requirements
- R1: After reset every total reads zero, the response channel is not valid, and the request channel is ready.
- R2: An episode adds exactly the number of cycles in which both the source's idle input and the tick enable were high. Cycles without a tick add nothing.
- R3: A total read while its source is still idle returns the value from before the episode began.
- R4: The update happens at the clock edge that ends the first non-idle cycle. After that edge the total equals the previous total plus the episode's tick count, and totals keep accumulating across episodes.
- R5: A read accepted in the same cycle as the idle exit returns the total from before the update.
- R6: A total wraps modulo 2^CNT_W and does not saturate.
- R7: While the capability input is low, every read returns zero, and an episode that ends then is discarded.
- R8: Source index NUM_THREADS counts ticks in cycles where at least one thread is idle. It is updated when the last idle thread leaves.
- R9: The aggregate idle output is high exactly when at least one thread's idle input is high.
- R10: The request is ready when there is no response or the response is being taken. A response that is stalled holds its data. An index above NUM_THREADS reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Reference timestamp tick enable |
| idle_i | input | NUM_THREADS | Forced-idle status, one bit per thread |
| cap_i | input | 1 | Capability strap; feature present when high |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Read request ready |
| req_sel_i | input | SEL_W | Source index to read |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_ready_i | input | 1 | Read response ready |
| rsp_data_o | output | CNT_W | Read response total |
| agg_idle_o | output | 1 | High while any thread is forced idle |

## Verification
The collision that matters is an idle exit and an accepted read of the same source in one cycle. The read must see the total from before the update, and the next read must see the sum. A directed case drops a thread's idle bit and issues the read in the same cycle. It expects the old total first and the sum afterwards. Random stimulus flips idle bits while reads are issued, and a bench model snapshots its totals before it applies that cycle's exits, which catches the same collision again and again on all sources, including the aggregate.

// File: rtl/idle_res_pkg.sv
package idle_res_pkg;

  typedef enum logic [1:0] {
    PH_BUSY  = 2'd0,
    PH_ENTER = 2'd1,
    PH_HOLD  = 2'd2,
    PH_EXIT  = 2'd3
  } phase_e;

  function automatic phase_e classify(input logic was_idle, input logic is_idle);
    if (is_idle) return was_idle ? PH_HOLD : PH_ENTER;
    return was_idle ? PH_EXIT : PH_BUSY;
  endfunction

endpackage

// File: rtl/idle_episode_acc.sv
module idle_episode_acc
  import idle_res_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int IVL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             idle_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] total_o
);

  logic             idle_q;
  logic [IVL_W-1:0] ivl_q;
  logic [CNT_W-1:0] total_q;
  phase_e           phase;

  assign phase   = classify(idle_q, idle_i);
  assign total_o = total_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q  <= 1'b0;
      ivl_q   <= '0;
      total_q <= '0;
    end else begin
      idle_q <= idle_i;
      unique case (phase)
        PH_ENTER: ivl_q <= IVL_W'(tick_i);
        PH_HOLD:  ivl_q <= ivl_q + IVL_W'(tick_i);
        PH_EXIT: begin
          if (en_i) total_q <= total_q + CNT_W'(ivl_q);
          ivl_q <= '0;
        end
        default:  ivl_q <= '0;
      endcase
    end
  end

  // R2
  busy_ivl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> (ivl_q == '0));

  // R3
  idle_total_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> $stable(total_o));

  // R4
  exit_lump_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && !idle_i && en_i) |=> (total_o == $past(total_o) + CNT_W'($past(ivl_q))));

  // R7
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(total_o));

endmodule

// File: rtl/idle_read_port.sv
module idle_read_port #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [DW-1:0] data_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [DW-1:0] rsp_data_o
);

  logic          v_q;
  logic [DW-1:0] d_q;

  assign req_ready_o = !v_q || rsp_ready_i;
  assign rsp_valid_o = v_q;
  assign rsp_data_o  = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (req_valid_i && req_ready_o) begin
      v_q <= 1'b1;
      d_q <= data_i;
    end else if (rsp_ready_i) begin
      v_q <= 1'b0;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

endmodule

// File: rtl/idle_residency.sv
module idle_residency #(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 64,
  parameter int IVL_W       = 32,
  parameter int SEL_W       = $clog2(NUM_THREADS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic [NUM_THREADS-1:0] idle_i,
  input  logic                   cap_i,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [SEL_W-1:0]       req_sel_i,
  output logic                   rsp_valid_o,
  input  logic                   rsp_ready_i,
  output logic [CNT_W-1:0]       rsp_data_o,
  output logic                   agg_idle_o
);

  localparam int NSRC = NUM_THREADS + 1;

  logic [CNT_W-1:0] totals [NSRC];
  logic [CNT_W-1:0] sel_data;

  assign agg_idle_o = |idle_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic src_idle;
    if (g < NUM_THREADS) begin : g_thread
      assign src_idle = idle_i[g];
    end else begin : g_core
      assign src_idle = agg_idle_o;
    end
    idle_episode_acc #(
      .CNT_W (CNT_W),
      .IVL_W (IVL_W)
    ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .idle_i  (src_idle),
      .en_i    (cap_i),
      .total_o (totals[g])
    );
  end

  always_comb begin
    sel_data = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cap_i && req_sel_i == SEL_W'(i)) sel_data = totals[i];
    end
  end

  idle_read_port #(
    .DW (CNT_W)
  ) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .data_i      (sel_data),
    .rsp_valid_o (rsp_valid_o),
    .rsp_ready_i (rsp_ready_i),
    .rsp_data_o  (rsp_data_o)
  );

  // R7
  nocap_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && !cap_i) |=> (rsp_data_o == '0));

  // R9
  agg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i != '0) |-> agg_idle_o);

endmodule

// File: tb/idle_residency_tb.sv
module idle_residency_tb;

  localparam int N  = 4;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [N-1:0] idle = '0;
  logic cap = 1'b1;
  logic req_valid = 1'b0;
  logic [SW-1:0] req_sel = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, agg;
  logic [63:0] rsp_data;

  logic s_idle = 1'b0;
  logic s_req_valid = 1'b0;
  logic s_req_ready, s_rsp_valid, s_agg;
  logic [7:0] s_rsp_data;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit started = 1'b0;

  always #5 clk = ~clk;

  idle_residency #(.NUM_THREADS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .idle_i(idle), .cap_i(cap),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_sel_i(req_sel),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_data_o(rsp_data),
    .agg_idle_o(agg));

  idle_residency #(.NUM_THREADS(1), .CNT_W(8), .IVL_W(8)) u_small (
    .clk(clk), .rst_n(rst_n), .tick_i(1'b1), .idle_i(s_idle), .cap_i(1'b1),
    .req_valid_i(s_req_valid), .req_ready_o(s_req_ready), .req_sel_i(1'b0),
    .rsp_valid_o(s_rsp_valid), .rsp_ready_i(1'b1), .rsp_data_o(s_rsp_data),
    .agg_idle_o(s_agg));

  // bench model
  logic [63:0] m_tot [N+1];
  logic [63:0] m_ivl [N+1];
  logic        m_prev [N+1];
  logic        m_rsp_v = 1'b0;
  logic [63:0] m_rsp_d = '0;
  string       m_lbl = "R4";

  function automatic logic src_idle(input int s);
    return (s < N) ? idle[s] : (idle != '0);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      summary();
    end
    if (!rst_n) begin
      m_rsp_v = 1'b0;
      m_rsp_d = '0;
      for (int s = 0; s <= N; s++) begin
        m_tot[s] = '0; m_ivl[s] = '0; m_prev[s] = 1'b0;
      end
    end else begin
      if (req_valid && (!m_rsp_v || rsp_ready)) begin
        m_rsp_v = 1'b1;
        if (int'(req_sel) > N) begin
          m_rsp_d = '0; m_lbl = "R10";
        end else if (!cap) begin
          m_rsp_d = '0; m_lbl = "R7";
        end else begin
          m_rsp_d = m_tot[req_sel];
          if (m_prev[req_sel] && !src_idle(int'(req_sel))) m_lbl = "R5";
          else if (int'(req_sel) == N) m_lbl = "R8";
          else if (src_idle(int'(req_sel))) m_lbl = "R3";
          else m_lbl = "R4";
        end
      end else if (rsp_ready) begin
        m_rsp_v = 1'b0;
      end
      for (int s = 0; s <= N; s++) begin
        if (src_idle(s)) begin
          m_ivl[s] = (m_prev[s] ? m_ivl[s] : 64'd0) + 64'(tick);
          m_ivl[s] = m_ivl[s] & 64'hFFFF_FFFF;
        end else begin
          if (m_prev[s] && cap) m_tot[s] = m_tot[s] + m_ivl[s];
          m_ivl[s] = '0;
        end
        m_prev[s] = src_idle(s);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      if (started) begin
        check("R1", {63'd0, rsp_valid}, 64'd0);
        check("R1", {63'd0, req_ready}, 64'd1);
      end
    end else if (started) begin
      check("R9", {63'd0, agg}, {63'd0, (idle != '0)});
      check("R10", {63'd0, req_ready}, {63'd0, (!m_rsp_v || rsp_ready)});
      check("R10", {63'd0, rsp_valid}, {63'd0, m_rsp_v});
      if (m_rsp_v) check(m_lbl, rsp_data, m_rsp_d);
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input int sel, output logic [63:0] d);
    req_valid = 1'b1;
    req_sel = SW'(sel);
    rsp_ready = 1'b1;
    step();
    req_valid = 1'b0;
    @(negedge clk);
    d = rsp_data;
    step();
  endtask

  task automatic s_rd(output logic [7:0] d);
    s_req_valid = 1'b1;
    step();
    s_req_valid = 1'b0;
    @(negedge clk);
    d = s_rsp_data;
    step();
  endtask

  initial begin
    logic [63:0] v;
    logic [7:0] sv;
    void'($urandom(32'd2718));
    started = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1: fresh totals
    rd(0, v); check("R1", v, 0);
    rd(N, v); check("R1", v, 0);

    // R8: threads 0 and 1 overlap, aggregate counts union
    tick = 1'b1;
    idle = 4'b0001; repeat (3) step();
    idle = 4'b0011; repeat (3) step();
    idle = 4'b0010; repeat (2) step();
    idle = 4'b0000; step();
    tick = 1'b0;
    rd(N, v); check("R8", v, 8);

    // R2: ticks on 7 of 20 idle cycles
    idle[2] = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick = (i % 3 == 0);
      step();
    end
    idle[2] = 1'b0; tick = 1'b0; step();
    rd(2, v); check("R2", v, 7);

    // R3: read during stall sees pre-episode value
    idle[3] = 1'b1; tick = 1'b1;
    repeat (5) step();
    tick = 1'b0;
    rd(3, v); check("R3", v, 0);
    idle[3] = 1'b0; step();
    rd(3, v); check("R4", v, 5);

    // R5: exit and read of thread 0 (total 6) in the same cycle
    idle[0] = 1'b1; tick = 1'b1;
    repeat (10) step();
    tick = 1'b0;
    idle[0] = 1'b0;
    rd(0, v); check("R5", v, 6);
    rd(0, v); check("R4", v, 16);

    // R7: capability low discards episode and reads zero
    cap = 1'b0;
    idle[3] = 1'b1; tick = 1'b1;
    repeat (5) step();
    idle[3] = 1'b0; tick = 1'b0; step();
    rd(3, v); check("R7", v, 0);
    cap = 1'b1;
    rd(3, v); check("R7", v, 5);

    // R10: index beyond aggregate reads zero; stalled response holds
    rd(5, v); check("R10", v, 0);
    rd(7, v); check("R10", v, 0);
    req_valid = 1'b1; req_sel = 3'd2; rsp_ready = 1'b0;
    step();
    req_valid = 1'b0;
    repeat (3) step();
    @(negedge clk);
    check("R10", rsp_data, 7);
    check("R10", {63'd0, rsp_valid}, 1);
    step();
    rsp_ready = 1'b1;
    step();

    // R6: 8-bit instance wraps
    s_idle = 1'b1; repeat (200) step();
    s_idle = 1'b0; step();
    s_rd(sv); check("R6", {56'd0, sv}, 200);
    s_idle = 1'b1; repeat (100) step();
    s_idle = 1'b0; step();
    s_rd(sv); check("R6", {56'd0, sv}, 44);

    // random traffic checked by the model
    for (int c = 0; c < 4000; c++) begin
      tick = $urandom % 2;
      for (int t = 0; t < N; t++) if ($urandom % 8 == 0) idle[t] = ~idle[t];
      cap = ($urandom % 16) != 0;
      req_valid = ($urandom % 3) == 0;
      req_sel = SW'($urandom % 6);
      rsp_ready = ($urandom % 4) != 0;
      step();
    end
    idle = '0; req_valid = 1'b0; rsp_ready = 1'b1; cap = 1'b1;
    step(); step();
    for (int s = 0; s <= N; s++) begin
      rd(s, v);
      check((s == N) ? "R8" : "R4", v, m_tot[s]);
    end
    summary();
  end

endmodule